// File: doc/BRIEF.md
# Two-Level Gated Interrupt Controller

This block gathers interrupt events from a small microcontroller into sticky flag bits and decides when the processor core is interrupted. Three core sources sit at the first level: an external pin edge, a port-change event and a timer overflow. Each is gated by its own enable. A parameterised group of up to nine peripheral sources is gated by its own per-source enables and then by a shared group enable. A global enable is applied on top of both levels. While the core is servicing a request, the global enable is cleared by hardware. The return-from-interrupt strobe sets it again.

Software reaches every flag and enable through write strobes and read-back words. The core control word has its own strobe. The peripheral flag words and the peripheral enable words each have one strobe per 8-bit word. A rising request reaches the core only after a fixed number of instruction-cycle ticks. The core supplies these ticks on `tick`. Because the tick phase is not tied to the event, the latency in clocks varies. A separate wake output tells a sleeping core that something is pending, whatever the global enable holds.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset, the control word and every peripheral flag and enable read 0. `irq_req` and `wake` are low.
- R2: An event on a source sets its flag on the next clock edge. This holds whether the source's enable, the group enable or the global enable is set or clear, and the flag stays set until software clears it.
- R3: A core source is pending when its flag and its enable are both 1. A peripheral source is pending when its flag, its enable and the group enable (control bit 1) are all 1.
- R4: `irq_req` is high only while the global enable (control bit 0) is 1 and at least one source is pending. Clearing the global enable by a software write drops the request in the same cycle that the write takes effect.
- R5: A cycle with `irq_ack` high clears the global enable on that clock edge. `irq_vec` always reads 0x0004.
- R6: A cycle with `irq_ret` high sets the global enable. If `irq_ack` is high in the same cycle, the clear wins.
- R7: Flags are not changed by `irq_ack`. A flag that is still set and enabled raises `irq_req` again right after `irq_ret`.
- R8: A newly pending source raises `irq_req` on the third `tick` edge at which it was sampled pending. That is 3 or 4 instruction cycles after the event, depending on its phase.
- R9: `wake` is high whenever any source is pending per R3, even while the global enable is 0.
- R10: If a source's event and a software write of 0 to its flag fall in the same cycle, the flag ends up set.
- R11: Each peripheral word strobe writes only its own 8 bits of flags or enables. Bits at or above NP read 0 and ignore writes. Peripheral source i sits at bit i of the flag and enable read buses.
- R12: Control word layout: bit 0 global enable, bit 1 group enable, bits 2/3/4 pin/port-change/timer enables, and bits 5/6/7 pin/port-change/timer flags. A write stores all eight bits, and a read returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Instruction-cycle boundary strobe from the core |
| core_evt | input | 3 | Core source events: bit 0 pin, bit 1 port change, bit 2 timer |
| periph_evt | input | NP | Peripheral source events |
| wr_core | input | 1 | Write strobe for the control word |
| wr_pflag | input | NW | Per-word write strobes for peripheral flags |
| wr_pen | input | NW | Per-word write strobes for peripheral enables |
| wdata | input | 8 | Write data shared by all strobes |
| irq_ack | input | 1 | Core is taking the interrupt |
| irq_ret | input | 1 | Core is executing return-from-interrupt |
| rd_core | output | 8 | Control word read-back |
| rd_pflag | output | NW*8 | Peripheral flag read-back |
| rd_pen | output | NW*8 | Peripheral enable read-back |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Vector address, 0x0004 |
| wake | output | 1 | Wake-up request to a sleeping core |

## Verification
Two pairs of events can land in the same cycle. The first pair is a hardware event and a software write that clears the same flag. The bench raises both on one edge, for a core source and for a peripheral source, and requires the flag to read 1 afterwards. The second pair is the take strobe and the return strobe. The bench asserts both together and requires the global enable to read 0. The latency is swept with the event placed at each of the four tick phases for every core source, and `irq_req` is compared on every clock against a count of the qualifying tick edges.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
   localparam int WORD_W  = 8;
   localparam int CORE_N  = 3;
   localparam int SRC_MAX = 12;
   // control word bit positions
   localparam int CW_GIE  = 0;
   localparam int CW_GRP  = 1;
   localparam int CW_EN0  = 2;
   localparam int CW_FL0  = 5;

   function automatic int words_for(input int n);
      return (n + WORD_W - 1) / WORD_W;
   endfunction
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank
   import irq_gate_pkg::*;
#(
   parameter int N  = 8,
   parameter int NW = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      evt,
   input  logic [NW-1:0]     wr,
   input  logic [WORD_W-1:0] wdata,
   output logic [N-1:0]      q
);
   if (NW != words_for(N)) begin : g_bad_nw
      $error("irq_sticky_bank: NW does not match N");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      localparam int WI = i / WORD_W;
      localparam int BI = i % WORD_W;
      logic r;
      // a hardware set outranks a software write in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        r <= 1'b0;
         else if (evt[i])   r <= 1'b1;
         else if (wr[WI])   r <= wdata[BI];
      end
      assign q[i] = r;
   end
endmodule

// File: rtl/irq_gate_logic.sv
module irq_gate_logic
   import irq_gate_pkg::*;
#(
   parameter int NP = 9
) (
   input  logic [CORE_N-1:0] cflag,
   input  logic [CORE_N-1:0] cen,
   input  logic              grp_en,
   input  logic [NP-1:0]     pflag,
   input  logic [NP-1:0]     pen,
   input  logic              gie,
   output logic              pending,
   output logic              live
);
   logic core_hit;
   logic per_hit;

   always_comb begin
      core_hit = |(cflag & cen);
      per_hit  = grp_en & (|(pflag & pen));
      pending  = core_hit | per_hit;
      live     = pending & gie;
   end
endmodule

// File: rtl/irq_lat_pipe.sv
module irq_lat_pipe #(
   parameter int STAGES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic din,
   output logic dout
);
   if (STAGES < 1) begin : g_bad
      $error("irq_lat_pipe: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    r <= 1'b0;
         else if (tick) r <= din;
      end
      assign dout = r;
   end else begin : g_many
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    sh <= '0;
         else if (tick) sh <= {sh[STAGES-2:0], din};
      end
      assign dout = sh[STAGES-1];
   end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
   import irq_gate_pkg::*;
#(
   parameter int                NP        = 9,
   parameter int                LAT_TICKS = 3,
   parameter int                VEC_W     = 16,
   parameter logic [VEC_W-1:0]  VEC_ADDR  = 'h0004,
   localparam int               NW        = words_for(NP)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic [CORE_N-1:0]    core_evt,
   input  logic [NP-1:0]        periph_evt,
   input  logic                 wr_core,
   input  logic [NW-1:0]        wr_pflag,
   input  logic [NW-1:0]        wr_pen,
   input  logic [WORD_W-1:0]    wdata,
   input  logic                 irq_ack,
   input  logic                 irq_ret,
   output logic [WORD_W-1:0]    rd_core,
   output logic [NW*WORD_W-1:0] rd_pflag,
   output logic [NW*WORD_W-1:0] rd_pen,
   output logic                 irq_req,
   output logic [VEC_W-1:0]     irq_vec,
   output logic                 wake
);
   if (NP < 1 || NP + CORE_N > SRC_MAX) begin : g_bad_np
      $error("irq_gate_ctrl: NP out of range");
   end
   if (LAT_TICKS < 1) begin : g_bad_lat
      $error("irq_gate_ctrl: LAT_TICKS must be at least 1");
   end
   if (VEC_W < 3) begin : g_bad_vec
      $error("irq_gate_ctrl: VEC_W too narrow");
   end

   logic              gie_q;
   logic              grp_q;
   logic [CORE_N-1:0] cflag_q;
   logic [CORE_N-1:0] cen_q;
   logic [NP-1:0]     pflag_q;
   logic [NP-1:0]     pen_q;
   logic              pending;
   logic              live;
   logic              piped;
   logic [WORD_W-1:0] wd_fl;
   logic [WORD_W-1:0] wd_en;

   assign wd_fl = wdata >> CW_FL0;
   assign wd_en = wdata >> CW_EN0;

   irq_sticky_bank #(.N(CORE_N), .NW(1)) u_cflag (
      .clk(clk), .rst_n(rst_n), .evt(core_evt), .wr(wr_core),
      .wdata(wd_fl), .q(cflag_q)
   );

   irq_sticky_bank #(.N(CORE_N), .NW(1)) u_cen (
      .clk(clk), .rst_n(rst_n), .evt({CORE_N{1'b0}}), .wr(wr_core),
      .wdata(wd_en), .q(cen_q)
   );

   irq_sticky_bank #(.N(NP), .NW(NW)) u_pflag (
      .clk(clk), .rst_n(rst_n), .evt(periph_evt), .wr(wr_pflag),
      .wdata(wdata), .q(pflag_q)
   );

   irq_sticky_bank #(.N(NP), .NW(NW)) u_pen (
      .clk(clk), .rst_n(rst_n), .evt({NP{1'b0}}), .wr(wr_pen),
      .wdata(wdata), .q(pen_q)
   );

   // global enable: take beats return, return beats software
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q <= 1'b0;
         grp_q <= 1'b0;
      end else begin
         if (irq_ack)      gie_q <= 1'b0;
         else if (irq_ret) gie_q <= 1'b1;
         else if (wr_core) gie_q <= wdata[CW_GIE];
         if (wr_core)      grp_q <= wdata[CW_GRP];
      end
   end

   irq_gate_logic #(.NP(NP)) u_gate (
      .cflag(cflag_q), .cen(cen_q), .grp_en(grp_q),
      .pflag(pflag_q), .pen(pen_q), .gie(gie_q),
      .pending(pending), .live(live)
   );

   irq_lat_pipe #(.STAGES(LAT_TICKS)) u_lat (
      .clk(clk), .rst_n(rst_n), .tick(tick), .din(pending), .dout(piped)
   );

   // delay applies to the rising side only; loss of pending or gie acts at once
   assign irq_req = piped & live;
   assign wake    = pending;
   assign irq_vec = VEC_ADDR;

   always_comb begin
      rd_core                   = '0;
      rd_core[CW_GIE]           = gie_q;
      rd_core[CW_GRP]           = grp_q;
      rd_core[CW_EN0 +: CORE_N] = cen_q;
      rd_core[CW_FL0 +: CORE_N] = cflag_q;
      rd_pflag                  = '0;
      rd_pflag[NP-1:0]          = pflag_q;
      rd_pen                    = '0;
      rd_pen[NP-1:0]            = pen_q;
   end
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk
   import irq_gate_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic [CORE_N-1:0] core_evt,
   input logic              irq_ack,
   input logic              irq_ret,
   input logic [WORD_W-1:0] rd_core,
   input logic              irq_req,
   input logic              wake
);
   assert_req_needs_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> rd_core[CW_GIE]);

   assert_ack_clears_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !rd_core[CW_GIE]);

   assert_ret_sets_gie_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !irq_ack) |=> rd_core[CW_GIE]);

   assert_pin_flag_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      core_evt[0] |=> rd_core[CW_FL0]);

   assert_timer_flag_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
      core_evt[2] |=> rd_core[CW_FL0 + 2]);

   assert_req_implies_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> wake);
endmodule

bind irq_gate_ctrl irq_gate_chk u_chk (
   .clk(clk), .rst_n(rst_n), .core_evt(core_evt), .irq_ack(irq_ack),
   .irq_ret(irq_ret), .rd_core(rd_core), .irq_req(irq_req), .wake(wake)
);

// File: tb/irq_gate_ctrl_tb.sv
`timescale 1ns/1ps
module irq_gate_ctrl_tb;
   localparam int NP = 9;
   localparam int NW = 2;
   localparam int L  = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [2:0]  core_evt = '0;
   logic [NP-1:0] periph_evt = '0;
   logic        wr_core = 1'b0;
   logic [NW-1:0] wr_pflag = '0;
   logic [NW-1:0] wr_pen = '0;
   logic [7:0]  wdata = '0;
   logic        irq_ack = 1'b0;
   logic        irq_ret = 1'b0;
   logic [7:0]  rd_core;
   logic [15:0] rd_pflag;
   logic [15:0] rd_pen;
   logic        irq_req;
   logic [15:0] irq_vec;
   logic        wake;

   int nvec = 0;
   int nbad = 0;
   int ph = 0;

   irq_gate_ctrl #(.NP(NP), .LAT_TICKS(L)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .core_evt(core_evt),
      .periph_evt(periph_evt), .wr_core(wr_core), .wr_pflag(wr_pflag),
      .wr_pen(wr_pen), .wdata(wdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
      .rd_core(rd_core), .rd_pflag(rd_pflag), .rd_pen(rd_pen),
      .irq_req(irq_req), .irq_vec(irq_vec), .wake(wake)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one clock; tick is high for one clock in four
   task automatic cyc();
      @(posedge clk);
      #1;
      ph++;
      tick = ((ph % 4) == 3);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic wcore(input logic [7:0] v);
      wr_core = 1'b1; wdata = v; cyc(); wr_core = 1'b0; wdata = '0;
   endtask

   task automatic wpf(input int w, input logic [7:0] v);
      wr_pflag = NW'(1 << w); wdata = v; cyc(); wr_pflag = '0; wdata = '0;
   endtask

   task automatic wpe(input int w, input logic [7:0] v);
      wr_pen = NW'(1 << w); wdata = v; cyc(); wr_pen = '0; wdata = '0;
   endtask

   initial begin
      #4_000_000;
      nbad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      logic [7:0] exp_w;
      // R1 reset state
      idle(3);
      chk("R1 rd_core", rd_core, 0);
      chk("R1 rd_pflag", rd_pflag, 0);
      chk("R1 rd_pen", rd_pen, 0);
      chk("R1 irq_req", irq_req, 0);
      chk("R1 wake", wake, 0);
      chk("R5 vector", irq_vec, 16'h0004);
      rst_n = 1'b1;
      cyc();

      // R2 every source latches with all enables clear
      for (int s = 0; s < 3 + NP; s++) begin
         if (s < 3) core_evt = 3'(1 << s);
         else       periph_evt = NP'(1 << (s - 3));
         cyc();
         core_evt = '0; periph_evt = '0;
         cyc();
         if (s < 3) chk("R2 core flag", rd_core, 32'(1 << (5 + s)));
         else       chk("R2 periph flag", rd_pflag, 32'(1 << (s - 3)));
         chk("R2 no irq", irq_req, 0);
         chk("R3 no wake without enable", wake, 0);
         if (s < 3) wcore(8'h00);
         else       wpf((s - 3) / 8, 8'h00);
         chk("R2 cleared", {rd_core, rd_pflag}, 0);
      end

      // R12 / R3 / R9 exhaustive control word
      for (int v = 0; v < 256; v++) begin
         wcore(8'(v));
         chk("R12 readback", rd_core, 32'(v));
         exp_w = 8'(v);
         chk("R9 wake core gating",
             wake, 32'((exp_w[5] & exp_w[2]) | (exp_w[6] & exp_w[3]) | (exp_w[7] & exp_w[4])));
      end
      wcore(8'h00);
      idle(16);

      // R11 word strobes and unimplemented bits
      wpf(1, 8'hFF);
      chk("R11 upper flag word", rd_pflag, 32'h0100);
      wpf(0, 8'hA5);
      chk("R11 lower flag word", rd_pflag, 32'h01A5);
      wpe(1, 8'hFF);
      chk("R11 upper enable word", rd_pen, 32'h0100);
      wpe(0, 8'h3C);
      chk("R11 lower enable word", rd_pen, 32'h013C);
      chk("R11 flags untouched by enable write", rd_pflag, 32'h01A5);
      chk("R3 group enable off", wake, 0);
      wcore(8'h02);
      chk("R3 group enable on", wake, 1);
      wcore(8'h00);
      wpf(0, 0); wpf(1, 0); wpe(0, 0); wpe(1, 0);

      // R3 each peripheral source under both group settings
      for (int i = 0; i < NP; i++) begin
         for (int g = 0; g < 2; g++) begin
            wpf(i / 8, 8'(1 << (i % 8)));
            wpe(i / 8, 8'(1 << (i % 8)));
            wcore(8'(g << 1));
            chk("R3 periph pending", wake, 32'(g));
            wpe(i / 8, 8'h00);
            chk("R3 periph enable off", wake, 0);
            wpf(i / 8, 8'h00);
         end
      end
      wcore(8'h00);

      // R10 event versus software clear in one cycle
      core_evt = 3'b100; wr_core = 1'b1; wdata = 8'h00;
      cyc();
      core_evt = '0; wr_core = 1'b0;
      chk("R10 core set wins", rd_core, 32'h80);
      periph_evt = NP'(1 << 8); wr_pflag = 2'b10; wdata = 8'h00;
      cyc();
      periph_evt = '0; wr_pflag = '0;
      chk("R10 periph set wins", rd_pflag, 32'h0100);
      wcore(8'h00); wpf(1, 8'h00);
      idle(16);

      // R4..R7 take / return handshake
      wcore(8'h91);
      idle(16);
      chk("R4 request raised", irq_req, 1);
      irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
      chk("R5 gie cleared by take", rd_core[0], 0);
      chk("R5 request dropped", irq_req, 0);
      chk("R5 vector", irq_vec, 16'h0004);
      chk("R7 flag kept", rd_core[7], 1);
      chk("R9 wake with gie clear", wake, 1);
      irq_ret = 1'b1; cyc(); irq_ret = 1'b0;
      chk("R6 gie set by return", rd_core[0], 1);
      chk("R7 request recurs", irq_req, 1);
      irq_ack = 1'b1; irq_ret = 1'b1; cyc(); irq_ack = 1'b0; irq_ret = 1'b0;
      chk("R6 take wins over return", rd_core[0], 0);
      irq_ret = 1'b1; cyc(); irq_ret = 1'b0;
      chk("R6 return again", irq_req, 1);
      wcore(8'h90);
      chk("R4 software clear of gie", irq_req, 0);
      chk("R4 flag still set", rd_core, 32'h90);
      wcore(8'h10);
      irq_ret = 1'b1; cyc(); irq_ret = 1'b0;
      chk("R7 no recurrence after flag clear", irq_req, 0);
      chk("R7 gie back", rd_core, 32'h11);

      // R8 latency over every phase and core source
      wcore(8'h1D);
      idle(16);
      for (int src = 0; src < 3; src++) begin
         for (int p = 0; p < 4; p++) begin
            int cnt;
            bit flagset;
            while ((ph % 4) != p) cyc();
            core_evt = 3'(1 << src);
            cnt = 0; flagset = 0;
            for (int k = 0; k < 20; k++) begin
               bit t;
               bit had;
               t = tick;
               had = (core_evt != 0);
               cyc();
               if (flagset && t) cnt++;
               if (had) begin
                  flagset = 1;
                  core_evt = '0;
               end
               chk("R8 latency", irq_req, 32'(cnt >= L));
            end
            wcore(8'h1D);
            idle(16);
            chk("R8 flushed", irq_req, 0);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule